// File: doc/BRIEF.md
# Trace Word Frame Unpacker

This block takes 32-bit words read out of a trace store and splits each word into the individual trace entries it contains. A two-bit width selector gives the capture port width used when the word was recorded. A 4-bit port packs three entries into a word, an 8-bit port packs two, and a 16-bit port packs one. Every emitted entry carries a 3-bit pipeline status, a packet field zero-extended to 16 bits, a sync flag and a trigger flag.

An entry whose raw status equals the trigger code is a trigger marker. For such an entry the block reports the low three packet bits as the status and raises the trigger flag. Words arrive on a valid/ready input channel. Entries leave on a valid/ready output channel, one per handshake, starting from the lowest bit position. A word is held until its last entry has been taken. The width selector is sampled only when a word is accepted.

Top module: `trace_word_unpacker`

## Requirements
- R1: While reset is asserted, and after it is released until a word is accepted, `outValid` is 0 and `inReady` is 1.
- R2: With `widthMode` = 2'b00 (4-bit port), a word yields 3 entries. Entry k (k = 0..2) takes its status from bits 8k+2:8k, its 4-bit packet from bits 8k+6:8k+3 and its sync flag from bit 8k+7.
- R3: With `widthMode` = 2'b01 (8-bit port), a word yields 2 entries. Entry 0 uses status 2:0, packet 10:3 and sync 11. Entry 1 uses status 14:12, packet 22:15 and sync 23.
- R4: With `widthMode` = 2'b10 or 2'b11 (16-bit port), a word yields 1 entry with status 2:0, packet 18:3 and sync 19.
- R5: When an entry's raw status equals `TRIG_CODE` (default 3'b111), `outStatus` carries packet bits 2:0 and `outTrigger` is 1. Otherwise `outTrigger` is 0 and `outStatus` is the raw status, which then never equals `TRIG_CODE`.
- R6: `outPacket` is 16 bits. Bits above the packet width of the active mode read as 0.
- R7: Entries leave in order of increasing bit position, one per cycle in which `outValid` and `outReady` are both 1. While `outReady` is 0, all entry outputs stay stable.
- R8: `inReady` is 0 while a word still has entries left to emit. The exception is the cycle in which its last entry is taken (`outReady` = 1), when a new word may be accepted.
- R9: The width selector is sampled when a word is accepted. A change of `widthMode` while a word is being emitted does not affect that word's entries.
- R10: The first entry of an accepted word is presented (`outValid` = 1) in the cycle after the accepting clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input word valid |
| inReady | output | 1 | Block can accept a word |
| inWord | input | 32 | Stored trace word |
| widthMode | input | 2 | Port width: 00 = 4-bit, 01 = 8-bit, 1x = 16-bit |
| outValid | output | 1 | Entry valid |
| outReady | input | 1 | Consumer takes the entry |
| outStatus | output | 3 | Pipeline status (replaced on trigger) |
| outPacket | output | 16 | Packet field, zero-extended |
| outSync | output | 1 | Sync flag |
| outTrigger | output | 1 | Entry was a trigger marker |

## Verification
The hardest situation to reach from the ports is the word boundary under backpressure. The last entry of a word has to be taken in the same cycle that a new word is offered, while the width selector has just changed. The bench reaches this with a long random phase. In that phase `outReady`, `inValid` and `widthMode` change every cycle, and raw status fields are forced to the trigger code often. As a result, back-to-back accepts, stalls on the last entry and mid-word mode changes all occur many times. A behavioural queue model predicts each entry and the expected `inReady` and `outValid` on every cycle.

// File: rtl/twu_pkg.sv
package twu_pkg;

  typedef enum logic [1:0] {
    MODE_NIBBLE = 2'b00,
    MODE_BYTE   = 2'b01,
    MODE_HALF   = 2'b10,
    MODE_HALF_B = 2'b11
  } portMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic step;
  } ctrlStrobe_t;

  localparam int NUM_MODES = 3;

endpackage

// File: rtl/twu_field_extract.sv
module twu_field_extract #(
  parameter int WORD_W = 32,
  parameter int STAT_W = 3,
  parameter int PKT_W = 16,
  parameter int FIELD_W = 4,
  parameter int SLOT_IDX_W = 2,
  parameter logic [STAT_W-1:0] TRIG_CODE = '1
) (
  input  logic [WORD_W-1:0]     word,
  input  logic [SLOT_IDX_W-1:0] slot,
  output logic [STAT_W-1:0]     stat,
  output logic [PKT_W-1:0]      pkt,
  output logic                  sync,
  output logic                  trig
);
  localparam int STRIDE = STAT_W + FIELD_W + 1;

  logic [WORD_W-1:0]  shifted;
  logic [STAT_W-1:0]  rawStat;
  logic [FIELD_W-1:0] rawPkt;

  always_comb begin
    shifted = word >> (int'(slot) * STRIDE);
    rawStat = shifted[STAT_W-1:0];
    rawPkt  = shifted[STAT_W +: FIELD_W];
    sync    = shifted[STAT_W + FIELD_W];
    trig    = (rawStat == TRIG_CODE);
    stat    = trig ? rawPkt[STAT_W-1:0] : rawStat;
    pkt     = PKT_W'(rawPkt);
  end
endmodule

// File: rtl/twu_control.sv
module twu_control
  import twu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        outReady,
  input  logic        isLast,
  output logic        inReady,
  output logic        outValid,
  output ctrlStrobe_t strobe
);
  logic holdQ;
  logic fire;
  logic finish;

  always_comb begin
    fire        = holdQ & outReady;
    finish      = fire & isLast;
    inReady     = ~holdQ | finish;
    strobe.load = inValid & inReady;
    strobe.step = fire & ~isLast;
    outValid    = holdQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) holdQ <= 1'b0;
    else if (strobe.load) holdQ <= 1'b1;
    else if (finish) holdQ <= 1'b0;
  end
endmodule

// File: rtl/twu_datapath.sv
module twu_datapath
  import twu_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int STAT_W = 3,
  parameter int PKT_W = 16,
  parameter int BASE_FIELD_W = 4,
  parameter logic [STAT_W-1:0] TRIG_CODE = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [WORD_W-1:0] inWord,
  input  logic [1:0]        widthMode,
  output logic              isLast,
  output logic [STAT_W-1:0] outStatus,
  output logic [PKT_W-1:0]  outPacket,
  output logic              outSync,
  output logic              outTrigger
);
  localparam int IDX_W = $clog2(NUM_MODES);

  logic [WORD_W-1:0] wordQ;
  logic [IDX_W-1:0]  modeQ;
  logic [IDX_W-1:0]  slotQ;
  logic [IDX_W-1:0]  modeIn;

  logic [STAT_W-1:0] candStat [NUM_MODES];
  logic [PKT_W-1:0]  candPkt  [NUM_MODES];
  logic              candSync [NUM_MODES];
  logic              candTrig [NUM_MODES];

  always_comb begin
    unique case (portMode_e'(widthMode))
      MODE_NIBBLE: modeIn = IDX_W'(0);
      MODE_BYTE:   modeIn = IDX_W'(1);
      default:     modeIn = IDX_W'(2);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordQ <= '0;
      modeQ <= '0;
      slotQ <= '0;
    end else if (strobe.load) begin
      wordQ <= inWord;
      modeQ <= modeIn;
      slotQ <= '0;
    end else if (strobe.step) begin
      slotQ <= slotQ + IDX_W'(1);
    end
  end

  // one extractor per port width; field width doubles per mode
  for (genvar g = 0; g < NUM_MODES; g++) begin : g_mode
    twu_field_extract #(
      .WORD_W(WORD_W), .STAT_W(STAT_W), .PKT_W(PKT_W),
      .FIELD_W(BASE_FIELD_W << g), .SLOT_IDX_W(IDX_W),
      .TRIG_CODE(TRIG_CODE)
    ) u_ext (
      .word(wordQ), .slot(slotQ),
      .stat(candStat[g]), .pkt(candPkt[g]),
      .sync(candSync[g]), .trig(candTrig[g])
    );
  end

  always_comb begin
    outStatus  = candStat[0];
    outPacket  = candPkt[0];
    outSync    = candSync[0];
    outTrigger = candTrig[0];
    for (int m = 1; m < NUM_MODES; m++) begin
      if (modeQ == IDX_W'(m)) begin
        outStatus  = candStat[m];
        outPacket  = candPkt[m];
        outSync    = candSync[m];
        outTrigger = candTrig[m];
      end
    end
    // entries per word: NUM_MODES - mode index
    isLast = (slotQ == IDX_W'(NUM_MODES - 1) - modeQ);
  end
endmodule

// File: rtl/trace_word_unpacker.sv
module trace_word_unpacker
  import twu_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int STAT_W = 3,
  parameter int PKT_W = 16,
  parameter logic [STAT_W-1:0] TRIG_CODE = 3'b111
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [WORD_W-1:0] inWord,
  input  logic [1:0]        widthMode,
  output logic              outValid,
  input  logic              outReady,
  output logic [STAT_W-1:0] outStatus,
  output logic [PKT_W-1:0]  outPacket,
  output logic              outSync,
  output logic              outTrigger
);
  ctrlStrobe_t strobe;
  logic        isLast;

  twu_control u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .outReady(outReady),
    .isLast(isLast), .inReady(inReady), .outValid(outValid), .strobe(strobe)
  );

  twu_datapath #(
    .WORD_W(WORD_W), .STAT_W(STAT_W), .PKT_W(PKT_W), .TRIG_CODE(TRIG_CODE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inWord(inWord),
    .widthMode(widthMode), .isLast(isLast), .outStatus(outStatus),
    .outPacket(outPacket), .outSync(outSync), .outTrigger(outTrigger)
  );
endmodule

// File: rtl/twu_checker.sv
module twu_checker #(
  parameter int STAT_W = 3,
  parameter int PKT_W = 16,
  parameter logic [STAT_W-1:0] TRIG_CODE = 3'b111
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inReady,
  input logic              outValid,
  input logic              outReady,
  input logic [STAT_W-1:0] outStatus,
  input logic [PKT_W-1:0]  outPacket,
  input logic              outSync,
  input logic              outTrigger
);
  AST_RESET_IDLE: assert property (@(posedge clk) !rstN |=> !outValid); // R1

  AST_STALL_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outStatus) && $stable(outPacket)
      && $stable(outSync) && $stable(outTrigger)); // R7

  AST_NO_EARLY_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |-> !inReady); // R8

  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady |=> outValid); // R10

  AST_PLAIN_NOT_TRIG: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outTrigger |-> outStatus != TRIG_CODE); // R5
endmodule

bind trace_word_unpacker twu_checker u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .outValid(outValid), .outReady(outReady), .outStatus(outStatus),
  .outPacket(outPacket), .outSync(outSync), .outTrigger(outTrigger)
);

// File: tb/trace_word_unpacker_tb.sv
module trace_word_unpacker_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [31:0] inWord = '0;
  logic [1:0]  widthMode = '0;
  logic        outValid;
  logic        outReady = 1'b0;
  logic [2:0]  outStatus;
  logic [15:0] outPacket;
  logic        outSync;
  logic        outTrigger;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    logic [2:0]  st;
    logic [15:0] pk;
    logic        sy;
    logic        tr;
    int          mi;
    logic [1:0]  rawMode;
  } entry_t;

  entry_t expQ[$];

  always #5 clk = ~clk;

  trace_word_unpacker u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inWord(inWord), .widthMode(widthMode), .outValid(outValid),
    .outReady(outReady), .outStatus(outStatus), .outPacket(outPacket),
    .outSync(outSync), .outTrigger(outTrigger)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic pushWord(input logic [31:0] w, input logic [1:0] m);
    int mi;
    mi = (m == 2'b00) ? 0 : (m == 2'b01) ? 1 : 2;
    for (int k = 0; k < 3 - mi; k++) begin
      entry_t e;
      int fw;
      int base;
      fw = 4 << mi;
      base = k * (fw + 4);
      e.st = 3'((w >> base) & 32'h7);
      e.pk = 16'((w >> (base + 3)) & ((32'h1 << fw) - 1));
      e.sy = w[base + 3 + fw];
      e.tr = (e.st == 3'b111);
      if (e.tr) e.st = e.pk[2:0];
      e.mi = mi;
      e.rawMode = m;
      expQ.push_back(e);
    end
  endtask

  function automatic string modeTag(input int mi);
    return (mi == 0) ? "R2" : (mi == 1) ? "R3" : "R4";
  endfunction

  logic [31:0] lastOut;
  bit          lastStall = 1'b0;

  task automatic oneCycle(input int readyPct, input int validPct, input int trigPct);
    logic [31:0] curOut;
    @(negedge clk);
    curOut = {outStatus, outPacket, outSync, outTrigger, 11'b0};
    check(outValid == (expQ.size() != 0), "R10 outValid", outValid, expQ.size() != 0);
    if (outValid && expQ.size() != 0) begin
      entry_t e;
      string tag;
      e = expQ[0];
      tag = e.tr ? "R5" : modeTag(e.mi);
      check({outStatus, outPacket, outSync, outTrigger} == {e.st, e.pk, e.sy, e.tr},
            tag, {outStatus, outPacket, outSync, outTrigger}, {e.st, e.pk, e.sy, e.tr});
      if (e.mi < 2)
        check((outPacket >> (4 << e.mi)) == 0, "R6 packet upper bits", outPacket, e.pk);
      if (widthMode != e.rawMode)
        check(outPacket == e.pk && outStatus == e.st, "R9 mode change mid-word",
              {outStatus, outPacket}, {e.st, e.pk});
      if (lastStall)
        check(curOut == lastOut, "R7 stall stability", curOut, lastOut);
    end
    outReady = (($urandom % 100) < readyPct);
    inValid = (($urandom % 100) < validPct);
    inWord = $urandom;
    if (($urandom % 100) < trigPct) inWord[2:0] = 3'b111;
    if (($urandom % 100) < trigPct) inWord[10:8] = 3'b111;
    if (($urandom % 100) < trigPct) inWord[14:12] = 3'b111;
    if (($urandom % 100) < trigPct) inWord[18:16] = 3'b111;
    widthMode = 2'($urandom);
    #1;
    check(inReady == (expQ.size() == 0 || (expQ.size() == 1 && outReady)), "R8 inReady",
          inReady, expQ.size() == 0 || (expQ.size() == 1 && outReady));
    lastStall = outValid && !outReady;
    lastOut = curOut;
    if (outValid && outReady && expQ.size() != 0) void'(expQ.pop_front());
    if (inValid && inReady) pushWord(inWord, widthMode);
  endtask

  initial begin
    repeat (3) begin
      @(negedge clk);
      check(outValid == 1'b0, "R1 outValid in reset", outValid, 0);
    end
    rstN = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0, "R1 outValid after reset", outValid, 0);
    check(inReady == 1'b1, "R1 inReady after reset", inReady, 1);
    // steady streaming, no backpressure
    for (int i = 0; i < 300; i++) oneCycle(100, 100, 30);
    // heavy random backpressure, mode changes, triggers
    for (int i = 0; i < 6000; i++) oneCycle(60, 70, 40);
    // drain
    for (int i = 0; i < 20; i++) oneCycle(100, 0, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule